// File: doc/BRIEF.md
# Direct-Mapped Write-Back Data Cache

This block is a small direct-mapped data cache that sits between a processor load/store port and a word-wide main-memory port. It keeps four lines of two 32-bit words each. Every line carries a stored tag, a valid flag and a modified flag. A lookup picks one line from the address and compares its tag once. Reads and writes that hit finish inside the cache with no memory traffic.

On a miss the controller first copies a modified victim line back to memory. It then loads the whole requested line, lowest word first, and replays the lookup, which now hits. A write miss therefore merges the new bytes into a freshly loaded line. A build parameter turns the block into a write-through cache. In that mode every store also goes to memory, and the processor waits for that store to complete.

The processor holds `cpu_req` with its command until it sees a single-cycle `cpu_ready`. The controller serves one request at a time, and its states are idle, lookup, write-back, fill and update.

Top module: `dmc_top`

## Requirements
- R1: Reset clears every valid and modified flag and holds `cpu_ready` and `mem_req` low. After reset the first access to any line is a miss that fetches from memory, with no write-back even if that line was modified before the reset.
- R2: Address fields: bits [1:0] pick the byte in a word, bit [2] picks the word in the 8-byte line, bits [4:3] pick one of the 4 lines, and bits [31:5] form the tag. A line word's memory address is {tag, line, word, 2'b00}.
- R3: A read hit raises `cpu_ready` with the cached word on `cpu_rdata` in the first cycle after the edge that accepts the request, and makes no memory transaction.
- R4: In write-back mode a write hit updates only the bytes whose `cpu_be` bit is set (`cpu_be[i]` covers data bits 8i+7:8i), marks the line modified, and makes no memory transaction.
- R5: A miss on a modified line first writes both words of the old line to memory, word 0 first, at the address rebuilt from the stored tag and the line number. The fill starts only after that.
- R6: A line fill reads both words of the requested line, word 0 first. A miss on a clean or invalid line issues no memory write.
- R7: A write miss loads the full line before merging the written bytes, so the other word of the line keeps its memory value.
- R8: A line filled by a read miss is clean, so evicting it later causes no write-back.
- R9: When WRITE_BACK is 0, every write, whether it hits or misses, also writes the merged word to memory. `cpu_ready` for that write rises only with that memory write's acknowledge, and no write-back sequence ever occurs.
- R10: `mem_req` stays high with stable `mem_addr` and `mem_we` until `mem_ack` is seen, and each acknowledge moves exactly one word. The controller drives no memory request while idle.
- R11: `cpu_ready` is a one-cycle pulse per request. A new request is sampled only in the idle state after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req | input | 1 | Processor request, held until `cpu_ready` |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 32 | Byte address |
| cpu_wdata | input | 32 | Write data |
| cpu_be | input | 4 | Byte enables for writes |
| cpu_ready | output | 1 | Request complete (one-cycle pulse) |
| cpu_rdata | output | 32 | Read data, valid with `cpu_ready` on reads |
| mem_req | output | 1 | Memory word transfer request |
| mem_we | output | 1 | 1 = memory write, 0 = memory read |
| mem_addr | output | 32 | Memory word address (byte aligned) |
| mem_wdata | output | 32 | Memory write data |
| mem_ack | input | 1 | Memory acknowledge, one per word |
| mem_rdata | input | 32 | Memory read data, valid with `mem_ack` |

## Verification
The bench targets the corner cases a cache can get subtly wrong, using a run of accesses that alias on the same line number with different tags. A design that dropped the write-back, or rebuilt the victim address from the new tag, would return stale data when the old address is read back. A design that skipped the fill on a write miss would corrupt the neighbouring word. A design that left read fills marked modified would show extra memory writes in the transaction counts. A second instance in write-through mode checks that stores reach memory before `cpu_ready` and that evictions never write back. A reset issued in the middle of the run checks that modified data cached before the reset is dropped without a write-back.

// File: rtl/dmc_pkg.sv
package dmc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOOKUP,
    ST_WRITEBACK,
    ST_FILL,
    ST_UPDATE
  } dmc_state_e;
endpackage

// File: rtl/dmc_store.sv
// Line storage: tags, data words, and per-line valid / modified flags.
module dmc_store #(
  parameter int DATA_W     = 32,
  parameter int LINES      = 4,
  parameter int LINE_WORDS = 2,
  parameter int TAG_W      = 27,
  localparam int IDX_W     = $clog2(LINES),
  localparam int WSEL_W    = $clog2(LINE_WORDS),
  localparam int BE_W      = DATA_W / 8
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic [IDX_W-1:0]                    idx,
  output logic [TAG_W-1:0]                    rd_tag,
  output logic                                rd_valid,
  output logic                                rd_dirty,
  output logic [LINE_WORDS-1:0][DATA_W-1:0]   rd_line,
  input  logic                                word_we,
  input  logic [WSEL_W-1:0]                   word_sel,
  input  logic [BE_W-1:0]                     word_be,
  input  logic [DATA_W-1:0]                   word_data,
  input  logic                                fill_done,
  input  logic [TAG_W-1:0]                    fill_tag,
  input  logic                                set_dirty
);
  logic [TAG_W-1:0]                  tag_q  [LINES];
  logic [LINE_WORDS-1:0][DATA_W-1:0] data_q [LINES];
  logic [LINES-1:0]                  valid_q, dirty_q;

  // Flags: the only state that is reset.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
      dirty_q <= '0;
    end else begin
      if (fill_done) begin
        valid_q[idx] <= 1'b1;
        dirty_q[idx] <= 1'b0;
      end
      if (set_dirty) dirty_q[idx] <= 1'b1;
    end
  end

  // Arrays: written under explicit enables, never reset.
  always_ff @(posedge clk) begin
    if (fill_done) tag_q[idx] <= fill_tag;
    for (int b = 0; b < BE_W; b++) begin
      if (word_we && word_be[b]) data_q[idx][word_sel][8*b +: 8] <= word_data[8*b +: 8];
    end
  end

  assign rd_tag   = tag_q[idx];
  assign rd_valid = valid_q[idx];
  assign rd_dirty = dirty_q[idx];
  assign rd_line  = data_q[idx];
endmodule

// File: rtl/dmc_lookup.sv
// Single tag comparator and word select for the indexed line.
module dmc_lookup #(
  parameter int DATA_W     = 32,
  parameter int LINE_WORDS = 2,
  parameter int TAG_W      = 27,
  localparam int WSEL_W    = $clog2(LINE_WORDS)
) (
  input  logic [LINE_WORDS-1:0][DATA_W-1:0] line,
  input  logic [TAG_W-1:0]                  stored_tag,
  input  logic                              stored_valid,
  input  logic [TAG_W-1:0]                  want_tag,
  input  logic [WSEL_W-1:0]                 want_word,
  output logic                              hit,
  output logic [DATA_W-1:0]                 word_out
);
  assign hit      = stored_valid && (stored_tag == want_tag);
  assign word_out = line[want_word];
endmodule

// File: rtl/dmc_top.sv
module dmc_top
  import dmc_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  parameter int LINES      = 4,
  parameter int LINE_WORDS = 2,
  parameter bit WRITE_BACK = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  input  logic [DATA_W/8-1:0] cpu_be,
  output logic              cpu_ready,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              mem_ack,
  input  logic [DATA_W-1:0] mem_rdata
);
  localparam int BE_W   = DATA_W / 8;
  localparam int BYTE_W = $clog2(BE_W);
  localparam int WSEL_W = $clog2(LINE_WORDS);
  localparam int IDX_W  = $clog2(LINES);
  localparam int TAG_W  = ADDR_W - IDX_W - WSEL_W - BYTE_W;
  localparam logic [WSEL_W-1:0] LAST_WORD = WSEL_W'(LINE_WORDS - 1);

  dmc_state_e          state_q, state_d;
  logic [WSEL_W-1:0]   cnt_q, cnt_d;
  logic [ADDR_W-1:0]   req_addr_q;
  logic                req_we_q;
  logic [DATA_W-1:0]   req_wdata_q;
  logic [BE_W-1:0]     req_be_q;
  logic                accept;

  logic [IDX_W-1:0]    req_idx;
  logic [WSEL_W-1:0]   req_word;
  logic [TAG_W-1:0]    req_tag;
  assign req_word = req_addr_q[BYTE_W +: WSEL_W];
  assign req_idx  = req_addr_q[BYTE_W+WSEL_W +: IDX_W];
  assign req_tag  = req_addr_q[ADDR_W-1 -: TAG_W];

  logic [TAG_W-1:0]                  rd_tag;
  logic                              rd_valid, rd_dirty, hit;
  logic [LINE_WORDS-1:0][DATA_W-1:0] rd_line;
  logic                              word_we, fill_done, set_dirty;
  logic [WSEL_W-1:0]                 word_sel;
  logic [BE_W-1:0]                   word_be;
  logic [DATA_W-1:0]                 word_data;

  dmc_store #(.DATA_W(DATA_W), .LINES(LINES), .LINE_WORDS(LINE_WORDS), .TAG_W(TAG_W)) u_store (
    .clk(clk), .rst_n(rst_n), .idx(req_idx),
    .rd_tag(rd_tag), .rd_valid(rd_valid), .rd_dirty(rd_dirty), .rd_line(rd_line),
    .word_we(word_we), .word_sel(word_sel), .word_be(word_be), .word_data(word_data),
    .fill_done(fill_done), .fill_tag(req_tag), .set_dirty(set_dirty)
  );

  dmc_lookup #(.DATA_W(DATA_W), .LINE_WORDS(LINE_WORDS), .TAG_W(TAG_W)) u_lookup (
    .line(rd_line), .stored_tag(rd_tag), .stored_valid(rd_valid),
    .want_tag(req_tag), .want_word(req_word), .hit(hit), .word_out(cpu_rdata)
  );

  // Policy variant: only write-back mode may mark a line modified.
  logic write_hit;
  generate
    if (WRITE_BACK) begin : g_wb
      assign set_dirty = write_hit;
    end else begin : g_wt
      assign set_dirty = 1'b0;
    end
  endgenerate

  always_comb begin
    state_d   = state_q;
    cnt_d     = cnt_q;
    accept    = 1'b0;
    cpu_ready = 1'b0;
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = '0;
    mem_wdata = '0;
    word_we   = 1'b0;
    word_sel  = req_word;
    word_be   = req_be_q;
    word_data = req_wdata_q;
    fill_done = 1'b0;
    write_hit = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (cpu_req) begin
          accept  = 1'b1;
          state_d = ST_LOOKUP;
        end
      end
      ST_LOOKUP: begin
        cnt_d = '0;
        if (hit) begin
          if (req_we_q) begin
            word_we   = 1'b1;
            write_hit = 1'b1;
            cpu_ready = WRITE_BACK;
            state_d   = WRITE_BACK ? ST_IDLE : ST_UPDATE;
          end else begin
            cpu_ready = 1'b1;
            state_d   = ST_IDLE;
          end
        end else begin
          state_d = (rd_valid && rd_dirty) ? ST_WRITEBACK : ST_FILL;
        end
      end
      ST_WRITEBACK: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = {rd_tag, req_idx, cnt_q, {BYTE_W{1'b0}}};
        mem_wdata = rd_line[cnt_q];
        if (mem_ack) begin
          cnt_d = cnt_q + WSEL_W'(1);
          if (cnt_q == LAST_WORD) state_d = ST_FILL;
        end
      end
      ST_FILL: begin
        mem_req  = 1'b1;
        mem_addr = {req_tag, req_idx, cnt_q, {BYTE_W{1'b0}}};
        if (mem_ack) begin
          word_we   = 1'b1;
          word_sel  = cnt_q;
          word_be   = '1;
          word_data = mem_rdata;
          cnt_d     = cnt_q + WSEL_W'(1);
          if (cnt_q == LAST_WORD) begin
            fill_done = 1'b1;
            state_d   = ST_LOOKUP;
          end
        end
      end
      ST_UPDATE: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = {req_tag, req_idx, req_word, {BYTE_W{1'b0}}};
        mem_wdata = rd_line[req_word];
        if (mem_ack) begin
          cpu_ready = 1'b1;
          state_d   = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (accept) begin
      req_addr_q  <= cpu_addr;
      req_we_q    <= cpu_we;
      req_wdata_q <= cpu_wdata;
      req_be_q    <= cpu_be;
    end
  end
endmodule

// File: rtl/dmc_checker.sv
module dmc_checker
  import dmc_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter bit WRITE_BACK = 1'b1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cpu_ready,
  input logic              mem_req,
  input logic              mem_we,
  input logic              mem_ack,
  input logic [ADDR_W-1:0] mem_addr,
  input dmc_state_e        state,
  input logic              req_we
);
  // R10: a pending memory request holds its command until acknowledged
  a_r10_mem_hold: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we));

  // R10: idle means no memory or processor activity
  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    state == ST_IDLE |-> !mem_req && !cpu_ready);

  // R11: completion is a single-cycle pulse
  a_r11_ready_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ready |=> !cpu_ready);

  // R3: completion without an acknowledge can only be a local hit
  a_r3_hit_local: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ready && !mem_ack |-> !mem_req && state == ST_LOOKUP);

  // R6: a fill only reads memory
  a_r6_fill_reads: assert property (@(posedge clk) disable iff (!rst_n)
    state == ST_FILL |-> mem_req && !mem_we);

  // R9: write-through stores complete together with their memory write
  a_r9_wt_write_acked: assert property (@(posedge clk) disable iff (!rst_n)
    !WRITE_BACK && cpu_ready && req_we |-> mem_ack && mem_we);

  // R9: write-through never evicts by write-back
  a_r9_wt_no_writeback: assert property (@(posedge clk) disable iff (!rst_n)
    !WRITE_BACK |-> state != ST_WRITEBACK);
endmodule

bind dmc_top dmc_checker #(.ADDR_W(ADDR_W), .WRITE_BACK(WRITE_BACK)) u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_ready(cpu_ready), .mem_req(mem_req),
  .mem_we(mem_we), .mem_ack(mem_ack), .mem_addr(mem_addr),
  .state(state_q), .req_we(req_we_q)
);

// File: tb/dmc_memsim.sv
// Bench memory: acknowledges each request one cycle later, logs addresses.
module dmc_memsim (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req,
  input  logic        we,
  input  logic [31:0] addr,
  input  logic [31:0] wdata,
  output logic        ack,
  output logic [31:0] rdata
);
  logic [31:0] mem   [64];
  logic [31:0] log_a [1024];
  int ops;

  initial begin
    ops = 0;
    for (int i = 0; i < 64; i++) mem[i] = 32'hA500_0000 + i;
  end

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) ack <= 1'b0;
    else if (ack) ack <= 1'b0;
    else if (req) begin
      ack <= 1'b1;
      if (we) mem[addr[7:2]] <= wdata;
      else rdata <= mem[addr[7:2]];
      log_a[ops % 1024] = addr;
      ops = ops + 1;
    end
  end
endmodule

// File: tb/dmc_top_test.sv
module dmc_top_test;
  localparam int CLK_NS = 10;

  logic clk = 1'b0;
  logic rst_n;
  always #(CLK_NS/2) clk = ~clk;

  logic        req_wb, req_wt, we;
  logic [31:0] addr, wdata;
  logic [3:0]  be;
  logic        rdy_wb, rdy_wt;
  logic [31:0] rd_wb, rd_wt;
  logic        mreq_wb, mwe_wb, mack_wb, mreq_wt, mwe_wt, mack_wt;
  logic [31:0] maddr_wb, mwd_wb, mrd_wb, maddr_wt, mwd_wt, mrd_wt;

  dmc_top uut (
    .clk(clk), .rst_n(rst_n), .cpu_req(req_wb), .cpu_we(we), .cpu_addr(addr),
    .cpu_wdata(wdata), .cpu_be(be), .cpu_ready(rdy_wb), .cpu_rdata(rd_wb),
    .mem_req(mreq_wb), .mem_we(mwe_wb), .mem_addr(maddr_wb), .mem_wdata(mwd_wb),
    .mem_ack(mack_wb), .mem_rdata(mrd_wb));

  dmc_top #(.WRITE_BACK(1'b0)) uut_wt (
    .clk(clk), .rst_n(rst_n), .cpu_req(req_wt), .cpu_we(we), .cpu_addr(addr),
    .cpu_wdata(wdata), .cpu_be(be), .cpu_ready(rdy_wt), .cpu_rdata(rd_wt),
    .mem_req(mreq_wt), .mem_we(mwe_wt), .mem_addr(maddr_wt), .mem_wdata(mwd_wt),
    .mem_ack(mack_wt), .mem_rdata(mrd_wt));

  dmc_memsim m_wb (.clk(clk), .rst_n(rst_n), .req(mreq_wb), .we(mwe_wb), .addr(maddr_wb),
                   .wdata(mwd_wb), .ack(mack_wb), .rdata(mrd_wb));
  dmc_memsim m_wt (.clk(clk), .rst_n(rst_n), .req(mreq_wt), .we(mwe_wt), .addr(maddr_wt),
                   .wdata(mwd_wt), .ack(mack_wt), .rdata(mrd_wt));

  int checks = 0;
  int errors = 0;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  // One processor access; returns read data, memory transactions and cycles.
  task automatic access(input bit wt, input bit w, input logic [31:0] a, input logic [31:0] d,
                        input logic [3:0] b, output logic [31:0] rd, output int nops,
                        output logic [31:0] first, output int cyc);
    int start;
    start = wt ? m_wt.ops : m_wb.ops;
    @(negedge clk);
    we = w; addr = a; wdata = d; be = b;
    if (wt) req_wt = 1'b1; else req_wb = 1'b1;
    cyc = 0;
    do begin
      @(posedge clk); #1; cyc++;
    end while (!(wt ? rdy_wt : rdy_wb) && cyc < 200);
    rd = wt ? rd_wt : rd_wb;
    req_wb = 1'b0; req_wt = 1'b0;
    if (cyc >= 200) check("R11 request never completed", 32'(cyc), 32'd0);
    nops  = (wt ? m_wt.ops : m_wb.ops) - start;
    first = wt ? m_wt.log_a[start % 1024] : m_wb.log_a[start % 1024];
    @(posedge clk); #1;
    check("R11 ready pulse ends", {31'd0, wt ? rdy_wt : rdy_wb}, 32'd0);
  endtask

  typedef struct packed {
    logic        w;
    logic [31:0] a;
    logic [31:0] d;
    logic [3:0]  b;
    logic [31:0] exp;
    logic [3:0]  nops;
    logic [31:0] first;
  } vec_t;

  // Write-back instance sequence; line 0/1/2/3 aliases chosen to force evictions.
  localparam vec_t VEC [15] = '{
    '{1'b0, 32'h00, 32'h0,        4'h0, 32'hA500_0000, 4'd2, 32'h00}, // R1 R6 cold miss
    '{1'b0, 32'h04, 32'h0,        4'h0, 32'hA500_0001, 4'd0, 32'h00}, // R3 hit word 1
    '{1'b1, 32'h00, 32'h1122_3344, 4'h3, 32'h0,        4'd0, 32'h00}, // R4 partial write hit
    '{1'b0, 32'h00, 32'h0,        4'h0, 32'hA500_3344, 4'd0, 32'h00}, // R4 merged bytes
    '{1'b0, 32'h20, 32'h0,        4'h0, 32'hA500_0008, 4'd4, 32'h00}, // R5 dirty eviction
    '{1'b0, 32'h00, 32'h0,        4'h0, 32'hA500_3344, 4'd2, 32'h00}, // R8 clean eviction
    '{1'b1, 32'h0C, 32'hDEAD_BEEF, 4'hF, 32'h0,        4'd2, 32'h08}, // R7 write miss
    '{1'b0, 32'h08, 32'h0,        4'h0, 32'hA500_0002, 4'd0, 32'h00}, // R7 neighbour kept
    '{1'b0, 32'h0C, 32'h0,        4'h0, 32'hDEAD_BEEF, 4'd0, 32'h00}, // R7 merged word
    '{1'b0, 32'h48, 32'h0,        4'h0, 32'hA500_0012, 4'd4, 32'h08}, // R5 R2 other tag
    '{1'b0, 32'h0C, 32'h0,        4'h0, 32'hDEAD_BEEF, 4'd2, 32'h08}, // R5 data survived
    '{1'b0, 32'h10, 32'h0,        4'h0, 32'hA500_0004, 4'd2, 32'h10}, // R2 line 2
    '{1'b0, 32'h30, 32'h0,        4'h0, 32'hA500_000C, 4'd2, 32'h30}, // R8 no write-back
    '{1'b1, 32'h1C, 32'h7700_0000, 4'h8, 32'h0,        4'd2, 32'h18}, // R7 byte 3 write miss
    '{1'b0, 32'h1C, 32'h0,        4'h0, 32'h7700_0007, 4'd0, 32'h00}  // R4 byte lane 3
  };

  initial begin
    #(CLK_NS * 200000);
    checks++; errors++;
    $display("FAIL watchdog expired actual running expected done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] rd, first;
    int nops, cyc;
    req_wb = 1'b0; req_wt = 1'b0; we = 1'b0; addr = '0; wdata = '0; be = '0;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    check("R1 ready low in reset", {31'd0, rdy_wb}, 32'd0);
    check("R1 mem_req low in reset", {31'd0, mreq_wb}, 32'd0);
    @(negedge clk); rst_n = 1'b1;

    for (int i = 0; i < 15; i++) begin
      access(1'b0, VEC[i].w, VEC[i].a, VEC[i].d, VEC[i].b, rd, nops, first, cyc);
      if (!VEC[i].w) check($sformatf("R3 R6 read data vec %0d", i), rd, VEC[i].exp);
      check($sformatf("R10 memory transfers vec %0d", i), 32'(nops), 32'(VEC[i].nops));
      if (nops > 0) check($sformatf("R2 R6 first address vec %0d", i), first, VEC[i].first);
      if (nops == 0) check($sformatf("R3 hit latency vec %0d", i), 32'(cyc), 32'd1);
      if (i == 4) begin
        check("R5 victim word 0 written back", m_wb.mem[0], 32'hA500_3344);
        check("R5 victim word 1 written back", m_wb.mem[1], 32'hA500_0001);
      end
      if (i == 9) begin
        check("R7 neighbour word in memory", m_wb.mem[2], 32'hA500_0002);
        check("R7 merged word in memory", m_wb.mem[3], 32'hDEAD_BEEF);
      end
    end

    // R1: reset drops the modified line 3 without writing it back.
    @(negedge clk); rst_n = 1'b0;
    @(posedge clk); #1;
    check("R1 ready low after reset", {31'd0, rdy_wb}, 32'd0);
    @(negedge clk); rst_n = 1'b1;
    access(1'b0, 1'b0, 32'h1C, 32'h0, 4'h0, rd, nops, first, cyc);
    check("R1 miss after reset", 32'(nops), 32'd2);
    check("R1 memory value after reset", rd, 32'hA500_0007);
    check("R1 no write-back after reset", m_wb.mem[7], 32'hA500_0007);

    // R9: write-through instance.
    access(1'b1, 1'b1, 32'h00, 32'hCAFE_F00D, 4'hF, rd, nops, first, cyc);
    check("R9 write miss fill plus store", 32'(nops), 32'd3);
    check("R9 store reached memory", m_wt.mem[0], 32'hCAFE_F00D);
    access(1'b1, 1'b1, 32'h04, 32'h0000_00AB, 4'h1, rd, nops, first, cyc);
    check("R9 write hit stores once", 32'(nops), 32'd1);
    check("R9 write hit address", first, 32'h04);
    check("R9 merged word in memory", m_wt.mem[1], 32'hA500_00AB);
    access(1'b1, 1'b0, 32'h20, 32'h0, 4'h0, rd, nops, first, cyc);
    check("R9 eviction without write-back", 32'(nops), 32'd2);
    check("R9 eviction fill address", first, 32'h20);
    check("R9 read data", rd, 32'hA500_0008);
    access(1'b1, 1'b0, 32'h04, 32'h0, 4'h0, rd, nops, first, cyc);
    check("R9 refetched store", rd, 32'hA500_00AB);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule